// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Bridge

This block sits between an external microprocessor bus and an array of 16-bit internal registers. It lets a host read and write those registers over one of four bus flavours. A 3-bit mode input picks the flavour. One mode bit chooses the strobe style: either separate active-low read and write strobes, or one active-low data strobe with a read/write select line. Another mode bit chooses an 8-bit or a 16-bit data path. The third mode bit enables the interface. The chip select, the strobes and the select line pass through a two-stage synchronizer on the system clock. Each strobe assertion produces exactly one single-cycle request on a plain internal register port.

The address comes from the host pins through a latch. The latch is transparent while the address latch enable input is high, so a non-multiplexed bus can tie that input high. When the input falls, the latch holds the address, which serves a bus that shares its address and data pins. The lowest address pin has two roles. On the 8-bit path it selects a byte of the register. On the 16-bit path it is a static byte-swap control.

The block models its tri-state pins as value and enable pairs. There is one enable for each data byte lane and one for the handshake pin. The handshake is an active-high ready signal in the separate-strobe style and an active-low acknowledge in the data-strobe style.

Top module: `hbus_bridge`

## Requirements
- R1: With mode bit 2 at 0 (for example mode 000), no register request is issued, and the handshake and data enables stay low, whatever the strobes do.
- R2: With mode bit 0 at 0, asserting the active-low read strobe (rd_ds_n) issues exactly one reg_re pulse. Asserting the active-low write strobe (wr_rw_n) issues exactly one reg_we pulse. Each pulse lasts one clock and comes once per strobe assertion.
- R3: With mode bit 0 at 1, rd_ds_n is an active-low data strobe and wr_rw_n selects the direction: 1 is a read and 0 is a write. Each assertion of the data strobe issues exactly one single-cycle request of that kind.
- R4: While cs_n is 1 or rst_n is 0, no request is issued, and hs_oe, d_oe_lo and d_oe_hi are all 0.
- R5: While ale is 1, the address pins pass straight through to reg_addr. After ale falls, the last address seen while ale was high is used, even if the pins then change.
- R6: With mode bit 1 at 0 (8-bit path), addr_a0 selects the byte. A value of 0 maps register bits 7:0 to data bits 7:0, and a value of 1 maps register bits 15:8 to data bits 7:0. A write drives reg_be to 01 or 10 respectively, so the other byte is untouched. A read never sets d_oe_hi.
- R7: With mode bit 1 at 1 (16-bit path), addr_a0 at 0 maps the bytes straight through and addr_a0 at 1 exchanges them. A write drives reg_be to 11, and a read sets both d_oe_lo and d_oe_hi.
- R8: While hs_oe is 1, hs_out signals "ready" as 1 in the separate-strobe style and as 0 in the data-strobe style. Before ready it holds the opposite level. hs_oe is 1 only while the bridge is enabled, selected and out of reset.
- R9: In a read, the handshake becomes ready exactly two clocks after the reg_re pulse. From that point d_out holds the steered register data.
- R10: In a write, the handshake becomes ready exactly one clock after the reg_we pulse. It returns to its not-ready level once the strobe has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Bit 2 enable, bit 1 data width (1 = 16-bit), bit 0 strobe style (1 = data strobe) |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Active-low read strobe, or active-low data strobe |
| wr_rw_n | input | 1 | Active-low write strobe, or read/write select (1 = read) |
| ale | input | 1 | Address latch enable: high = transparent, falling edge holds |
| addr_pins | input | AW | Register word address from the host |
| addr_a0 | input | 1 | Byte select (8-bit path) or byte swap (16-bit path) |
| d_in | input | 16 | Data bus value driven by the host |
| d_out | output | 16 | Data bus value driven by the bridge on reads |
| d_oe_lo | output | 1 | Drive enable for data bits 7:0 |
| d_oe_hi | output | 1 | Drive enable for data bits 15:8 |
| hs_out | output | 1 | Handshake pin value |
| hs_oe | output | 1 | Handshake pin drive enable |
| reg_addr | output | AW | Internal register word address |
| reg_wdata | output | 16 | Internal write data, already byte-steered |
| reg_be | output | 2 | Internal byte enables for writes |
| reg_we | output | 1 | Single-cycle internal write request |
| reg_re | output | 1 | Single-cycle internal read request |
| reg_rdata | input | 16 | Internal read data for reg_addr |

## Verification
A wrong sequencer state shows up at the ports within one to three clocks. The symptoms are a second request pulse for a single strobe, a handshake that goes ready one clock early or late relative to reg_re or reg_we, or a handshake that stays ready after the strobe is released. A corrupted address latch shows up as a write landing at the pin value that followed the ale fall rather than the one before it, visible when that register is read back. Lane-steering faults show up on the first access of the affected mode, as a wrong reg_be, a swapped byte on d_out or a set d_oe_hi on the 8-bit path.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int DATA_W = 16;
  localparam int LANE_W = DATA_W / 2;
  localparam int BE_W   = DATA_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD2,
    ST_WR,
    ST_ACK
  } hbus_state_e;

  function automatic logic mode_enabled(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_wide(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic mode_dstrobe(input logic [2:0] m);
    return m[0];
  endfunction

  // Steering of host data onto the register port: {byte enables, write data}
  function automatic logic [BE_W+DATA_W-1:0] lane_write(input logic wide,
                                                        input logic a0,
                                                        input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] w;
    logic [BE_W-1:0]   be;
    if (wide) begin
      be = '1;
      w  = a0 ? {d[LANE_W-1:0], d[DATA_W-1:LANE_W]} : d;
    end else begin
      be = a0 ? 2'b10 : 2'b01;
      w  = a0 ? {d[LANE_W-1:0], {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, d[LANE_W-1:0]};
    end
    return {be, w};
  endfunction

  // Steering of register data onto the host data bus
  function automatic logic [DATA_W-1:0] lane_read(input logic wide,
                                                  input logic a0,
                                                  input logic [DATA_W-1:0] r);
    if (wide)
      return a0 ? {r[LANE_W-1:0], r[DATA_W-1:LANE_W]} : r;
    return a0 ? {{LANE_W{1'b0}}, r[DATA_W-1:LANE_W]} : {{LANE_W{1'b0}}, r[LANE_W-1:0]};
  endfunction

  // Pin level of the handshake for a given internal "ready" state
  function automatic logic hs_level(input logic ready, input logic dstrobe);
    return dstrobe ? ~ready : ready;
  endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [AW-1:0] addr_pins,
  input  logic          a0_pin,
  output logic [AW-1:0] eff_addr,
  output logic          eff_a0
);

  logic [AW-1:0] held_addr;
  logic          held_a0;

  // Loads on every clock while ale is high, so after ale falls it keeps
  // the last address seen during the high phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_a0   <= 1'b0;
    end else if (ale) begin
      held_addr <= addr_pins;
      held_a0   <= a0_pin;
    end
  end

  assign eff_addr = ale ? addr_pins : held_addr;
  assign eff_a0   = ale ? a0_pin    : held_a0;

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              cs_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic [AW-1:0]     eff_addr,
  input  logic              eff_a0,
  input  logic [DATA_W-1:0] d_in,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [AW-1:0]     reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [BE_W-1:0]   reg_be,
  output logic              reg_we,
  output logic              reg_re,
  output logic [DATA_W-1:0] d_hold,
  output logic              rd_drive,
  output logic              hs_go,
  output logic              acc_start
);

  hbus_state_e state;
  logic        strobe_on;
  logic        strobe_q;
  logic        want_rd;
  logic        acc_a0;
  logic        acc_is_rd;
  logic        en;
  logic        dstb;

  assign en   = mode_enabled(mode);
  assign dstb = mode_dstrobe(mode);

  // Access window as seen through the synchronizer
  assign strobe_on = en & ~cs_s & (dstb ? ~rd_s : (~rd_s | ~wr_s));
  assign want_rd   = dstb ? wr_s : ~rd_s;
  assign acc_start = strobe_on & ~strobe_q & (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_be    <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      d_hold    <= '0;
      acc_a0    <= 1'b0;
      acc_is_rd <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acc_start) begin
            reg_addr  <= eff_addr;
            acc_a0    <= eff_a0;
            acc_is_rd <= want_rd;
            if (want_rd) begin
              reg_re <= 1'b1;
              state  <= ST_RD;
            end else begin
              reg_we              <= 1'b1;
              {reg_be, reg_wdata} <= lane_write(mode_wide(mode), eff_a0, d_in);
              state               <= ST_WR;
            end
          end
        end
        ST_RD: begin
          d_hold <= lane_read(mode_wide(mode), acc_a0, reg_rdata);
          state  <= ST_RD2;
        end
        ST_RD2:  state <= ST_ACK;
        ST_WR:   state <= ST_ACK;
        ST_ACK:  if (!strobe_on) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hs_go    = (state == ST_ACK);
  assign rd_drive = acc_is_rd & ((state == ST_RD2) | (state == ST_ACK));

endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge
  import hbus_pkg::*;
#(
  parameter int AW      = 10,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              cs_n,
  input  logic              rd_ds_n,
  input  logic              wr_rw_n,
  input  logic              ale,
  input  logic [AW-1:0]     addr_pins,
  input  logic              addr_a0,
  input  logic [15:0]       d_in,
  output logic [15:0]       d_out,
  output logic              d_oe_lo,
  output logic              d_oe_hi,
  output logic              hs_out,
  output logic              hs_oe,
  output logic [AW-1:0]     reg_addr,
  output logic [15:0]       reg_wdata,
  output logic [1:0]        reg_be,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [15:0]       reg_rdata
);

  localparam int CTL_W = 3;

  logic [CTL_W-1:0] ctl_s;
  logic [AW-1:0]    eff_addr;
  logic             eff_a0;
  logic [15:0]      d_hold;
  logic             rd_drive;
  logic             hs_go;
  logic             acc_start;
  logic             selected;

  hbus_sync #(.W(CTL_W), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, rd_ds_n, wr_rw_n}),
    .q     (ctl_s)
  );

  hbus_addr_latch #(.AW(AW)) u_alat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .addr_pins (addr_pins),
    .a0_pin    (addr_a0),
    .eff_addr  (eff_addr),
    .eff_a0    (eff_a0)
  );

  hbus_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cs_s      (ctl_s[2]),
    .rd_s      (ctl_s[1]),
    .wr_s      (ctl_s[0]),
    .eff_addr  (eff_addr),
    .eff_a0    (eff_a0),
    .d_in      (d_in),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_be    (reg_be),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .d_hold    (d_hold),
    .rd_drive  (rd_drive),
    .hs_go     (hs_go),
    .acc_start (acc_start)
  );

  // Pin enables follow the raw select so the pins float as soon as it drops
  assign selected = rst_n & ~cs_n & mode_enabled(mode);
  assign hs_oe    = selected;
  assign hs_out   = hs_level(hs_go, mode_dstrobe(mode));
  assign d_oe_lo  = selected & rd_drive;
  assign d_oe_hi  = selected & rd_drive & mode_wide(mode);
  assign d_out    = d_hold;

endmodule

// File: rtl/hbus_bridge_chk.sv
module hbus_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       cs_n,
  input logic       reg_re,
  input logic       reg_we,
  input logic [1:0] reg_be,
  input logic       hs_go,
  input logic       hs_oe,
  input logic       d_oe_lo,
  input logic       d_oe_hi
);

  // R2 / R3: every request is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re | reg_we) |=> !(reg_re | reg_we));

  a_r3_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_re && reg_we));

  // R1: a disabled bridge issues nothing
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2] && $past(!mode[2])) |-> !(reg_re | reg_we | hs_oe));

  // R4: nothing is driven while deselected
  a_r4_unselected_float: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(hs_oe | d_oe_lo | d_oe_hi));

  // R6: narrow path writes one byte and never drives the upper lane
  a_r6_narrow_be: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !mode[1]) |-> ($countones(reg_be) == 1));

  a_r6_upper_float: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> !d_oe_hi);

  // R7: wide path writes both bytes
  a_r7_wide_be: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && mode[1]) |-> (reg_be == 2'b11));

  // R9: ready two clocks after the read request
  a_r9_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !hs_go);

  a_r9_read_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> ##2 hs_go);

  // R10: ready one clock after the write request
  a_r10_write_ready: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> hs_go);

endmodule

bind hbus_bridge hbus_bridge_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (mode),
  .cs_n    (cs_n),
  .reg_re  (reg_re),
  .reg_we  (reg_we),
  .reg_be  (reg_be),
  .hs_go   (hs_go),
  .hs_oe   (hs_oe),
  .d_oe_lo (d_oe_lo),
  .d_oe_hi (d_oe_hi)
);

// File: tb/sim_hbus_bridge.sv
`timescale 1ns/1ps
module sim_hbus_bridge;

  localparam int AW = 10;
  localparam int NV = 8;
  // fields: mode[30:28] mux[27] addr[26:17] a0[16] data[15:0]
  localparam logic [30:0] VECS [0:NV-1] = '{
    {3'b110, 1'b0, 10'h005, 1'b0, 16'hA55A},
    {3'b110, 1'b1, 10'h006, 1'b1, 16'h1234},
    {3'b111, 1'b0, 10'h007, 1'b0, 16'hBEEF},
    {3'b111, 1'b1, 10'h008, 1'b1, 16'hC0DE},
    {3'b100, 1'b0, 10'h005, 1'b1, 16'h0077},
    {3'b100, 1'b1, 10'h009, 1'b0, 16'h00E1},
    {3'b101, 1'b0, 10'h00A, 1'b1, 16'h0042},
    {3'b101, 1'b1, 10'h006, 1'b0, 16'h0099}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'b110;
  logic          cs_n = 1'b1;
  logic          rd_ds_n = 1'b1;
  logic          wr_rw_n = 1'b1;
  logic          ale = 1'b1;
  logic [AW-1:0] addr_pins = '0;
  logic          addr_a0 = 1'b0;
  logic [15:0]   d_in = '0;
  logic [15:0]   d_out;
  logic          d_oe_lo, d_oe_hi, hs_out, hs_oe;
  logic [AW-1:0] reg_addr;
  logic [15:0]   reg_wdata;
  logic [1:0]    reg_be;
  logic          reg_we, reg_re;
  logic [15:0]   reg_rdata;

  logic [15:0]   mem    [0:(1<<AW)-1];
  logic [15:0]   shadow [0:(1<<AW)-1];
  int            n_req = 0;
  int            tests = 0;
  int            fails = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  hbus_bridge #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_ds_n(rd_ds_n),
    .wr_rw_n(wr_rw_n), .ale(ale), .addr_pins(addr_pins), .addr_a0(addr_a0),
    .d_in(d_in), .d_out(d_out), .d_oe_lo(d_oe_lo), .d_oe_hi(d_oe_hi),
    .hs_out(hs_out), .hs_oe(hs_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Behavioural register array behind the internal port
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
    end else begin
      if (reg_we) begin
        if (reg_be[0]) mem[reg_addr][7:0]  <= reg_wdata[7:0];
        if (reg_be[1]) mem[reg_addr][15:8] <= reg_wdata[15:8];
      end
      if (reg_we | reg_re) n_req <= n_req + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One host access; checks handshake, latency, data, enables.
  task automatic host_access(input logic [2:0] md, input logic mux, input logic is_rd,
                             input logic [AW-1:0] adr, input logic a0,
                             input logic [15:0] wd);
    int          k_req;
    int          k_rdy;
    int          req0;
    bit          idle_ok;
    logic [15:0] sh;
    logic [15:0] exp_d;
    logic        ready_lvl;
    ready_lvl = md[0] ? 1'b0 : 1'b1;
    k_req = -1; k_rdy = -1; idle_ok = 1;
    @(negedge clk);
    mode = md; addr_pins = adr; addr_a0 = a0; ale = 1'b1; d_in = wd;
    if (mux) begin
      repeat (2) @(negedge clk);
      ale = 1'b0;
      @(negedge clk);
      addr_pins = ~adr;                      // R5: pins change after the latch closed
      if (!md[1]) addr_a0 = ~a0;
    end
    req0 = n_req;
    cs_n = 1'b0;
    if (md[0]) wr_rw_n = is_rd;
    @(negedge clk);
    if (md[0]) rd_ds_n = 1'b0;
    else if (is_rd) rd_ds_n = 1'b0;
    else wr_rw_n = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if ((reg_re | reg_we) && k_req < 0) k_req = k;
      if (hs_oe && hs_out == ready_lvl) begin
        k_rdy = k;
        break;
      end
      if (!hs_oe || hs_out == ready_lvl) idle_ok = 0;
    end
    chk(idle_ok, "R8 handshake not-ready level while selected", {31'd0, hs_out}, {31'd0, ~ready_lvl});
    chk(k_rdy > 0, "R8 handshake reached ready level", k_rdy, 1);
    if (is_rd)
      chk(k_rdy - k_req == 2, "R9 read ready two clocks after reg_re", k_rdy - k_req, 2);
    else
      chk(k_rdy - k_req == 1, "R10 write ready one clock after reg_we", k_rdy - k_req, 1);
    if (is_rd) begin
      sh = shadow[adr];
      if (md[1]) begin
        exp_d = a0 ? {sh[7:0], sh[15:8]} : sh;
        chk(d_out == exp_d, "R7 wide read data", d_out, exp_d);
        chk(d_oe_lo && d_oe_hi, "R7 wide read drives both lanes", {d_oe_hi, d_oe_lo}, 2'b11);
      end else begin
        exp_d = {8'h00, a0 ? sh[15:8] : sh[7:0]};
        chk(d_out[7:0] == exp_d[7:0], "R6 narrow read byte", d_out[7:0], exp_d[7:0]);
        chk(d_oe_lo && !d_oe_hi, "R6 narrow read lane enables", {d_oe_hi, d_oe_lo}, 2'b01);
      end
    end
    if (md[0]) rd_ds_n = 1'b1;
    rd_ds_n = 1'b1; wr_rw_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hs_oe && hs_out != ready_lvl, "R10 handshake released after strobe", {hs_oe, hs_out}, {1'b1, ~ready_lvl});
    chk(n_req == req0 + 1, md[0] ? "R3 one request per data strobe" : "R2 one request per strobe", n_req - req0, 1);
    if (!is_rd) begin
      if (md[1]) shadow[adr] = a0 ? {wd[7:0], wd[15:8]} : wd;
      else if (a0) shadow[adr][15:8] = wd[7:0];
      else shadow[adr][7:0] = wd[7:0];
      chk(mem[adr] == shadow[adr], "R5 write landed at latched address", mem[adr], shadow[adr]);
      if (mux)
        chk(mem[~adr] == shadow[~adr], "R5 post-latch pin address untouched", mem[~adr], shadow[~adr]);
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk(!hs_oe && !d_oe_lo && !d_oe_hi, "R4 pins float when deselected", {hs_oe, d_oe_hi, d_oe_lo}, 0);
    ale = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!hs_oe && !d_oe_lo && !d_oe_hi, "R4 pins float in reset", {hs_oe, d_oe_hi, d_oe_lo}, 0);
    chk(!reg_we && !reg_re, "R4 no request in reset", {reg_we, reg_re}, 0);
    cs_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      host_access(VECS[v][30:28], VECS[v][27], 1'b0, VECS[v][26:17], VECS[v][16], VECS[v][15:0]);
      host_access(VECS[v][30:28], VECS[v][27], 1'b1, VECS[v][26:17], VECS[v][16], 16'h0);
      host_access(3'b110, 1'b0, 1'b1, VECS[v][26:17], 1'b0, 16'h0);   // R6/R7 full word check
    end

    // R1: disabled mode ignores strobes
    begin
      int r0;
      r0 = n_req;
      @(negedge clk);
      mode = 3'b000; cs_n = 1'b0; rd_ds_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(!hs_oe && !d_oe_lo, "R1 disabled bridge floats pins", {hs_oe, d_oe_lo}, 0);
      rd_ds_n = 1'b1; wr_rw_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_req == r0, "R1 disabled bridge issues no request", n_req - r0, 0);
      wr_rw_n = 1'b1; cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R4: strobes with chip select high do nothing
    begin
      int r0;
      r0 = n_req;
      mode = 3'b110; cs_n = 1'b1; wr_rw_n = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_req == r0 && !hs_oe, "R4 no access without chip select", n_req - r0, 0);
      wr_rw_n = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R2: a held write strobe still yields one pulse; data then reads back
    host_access(3'b110, 1'b0, 1'b0, 10'h3FF, 1'b0, 16'h5AA5);
    host_access(3'b111, 1'b0, 1'b1, 10'h3FF, 1'b1, 16'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule